// File: doc/BRIEF.md
# Back Channel GPIO Slot Mapper

The block fills the GPIO slots of a serial back channel frame. Each receive port has four slots, and each slot picks its value from one source. The sources are seven general-purpose inputs, an internal frame-sync signal, an external frame-sync signal, or a constant. The general-purpose inputs first pass through a two-flop synchronizer. The frame-sync signals are already in the clock domain. Each port's slot selects are held in two 8-bit control registers, and software writes and reads them through a small address/data port.

Each port has its own bit enable. The block counts 30 bit enables per back channel frame. On the first bit of every frame it captures all four slot values at once and raises a one-cycle strobe for the frame builder. The slot outputs then stay steady until the next frame start. As a result, the sampling rate is 1/30 of the bit rate: with a 10 Mbps back channel this is about 333 kHz.

Top module: `bc_gpio_slot_mapper`

## Requirements
- R1: After reset, every slot output and every strobe is 0. Every control register reads 0x99, so all slots select forced 0.
- R2: A write with `reg_we_i` high stores `reg_wdata_i` into the register addressed by `reg_port_i` and `reg_idx_i`. `reg_rdata_o` shows the addressed register from the next cycle on. Registers of other ports or indexes do not change.
- R3: The slot select is 4 bits. Register index 0 holds slot 0 in bits 3:0 and slot 1 in bits 7:4. Index 1 holds slot 2 in bits 3:0 and slot 3 in bits 7:4. Codes 0 to 6 select `gpio_i` bit 0 to 6. The captured value is the pin level from two clock edges before the capture edge.
- R4: One GPIO can be selected by several slots at once, and each of those slots carries its value.
- R5: Code 7 selects `fsync_int_i` and code 8 selects `fsync_ext_i`. Each is sampled directly on the capture edge.
- R6: Code 9 gives 0 and code 10 gives 1. Codes 11 to 15 give 0.
- R7: Each port counts its own bit enables, and one frame is 30 of them. Capture happens on the bit enable that starts a frame: the first one after reset, and then every 30th one. Other bit enables do not capture.
- R8: Slot outputs change only on the edge where the capture happens, and then hold. `frame_strobe_o` for that port is high for exactly the cycle after the capture edge.
- R9: Ports are independent. The bit enables and registers of one port never change another port's slots or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | NUM_GPIO | Asynchronous GPIO input levels |
| fsync_int_i | input | 1 | Internally generated frame sync, clock domain |
| fsync_ext_i | input | 1 | External frame sync, clock domain |
| bit_en_i | input | NUM_PORTS | Per-port back channel bit enable |
| reg_we_i | input | 1 | Control register write enable |
| reg_port_i | input | PORT_W | Port address of the control register |
| reg_idx_i | input | 1 | Register index within the port |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| slot_o | output | NUM_PORTS*4 | Captured slot bits, port p slot s at bit p*4+s |
| frame_strobe_o | output | NUM_PORTS | Per-port capture strobe |

## Verification
The bench runs several select patterns on one port. The first maps distinct pins to each slot, which shows that the select nibble decodes to the correct bit. The second repeats one pin across slots, which shows that a source is not used up once selected. Frame-sync patterns with opposite levels on the two syncs show that codes 7 and 8 are not swapped. Constant and out-of-range codes show how unused codes behave. A pin change placed right before a capture edge tests the synchronizer depth. A pin change placed in the middle of a frame must not appear until the 30-bit count wraps, which separates per-frame capture from continuous sampling.

// File: rtl/bcgm_pkg.sv
package bcgm_pkg;
  localparam int SEL_W      = 4;
  localparam int REG_W      = 8;
  localparam int SLOTS_PER_REG = REG_W / SEL_W;
  localparam logic [REG_W-1:0] CFG_RST = 8'h99;
endpackage

// File: rtl/bcgm_sync.sv
module bcgm_sync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bcgm_slot_mux.sv
module bcgm_slot_mux
  import bcgm_pkg::*;
#(
  parameter int NUM_GPIO = 7
) (
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_GPIO-1:0] gpio_i,
  input  logic                fs_int_i,
  input  logic                fs_ext_i,
  output logic                bit_o
);
  localparam int NSRC      = 2 ** SEL_W;
  localparam int CODE_FSI  = NUM_GPIO;
  localparam int CODE_FSE  = NUM_GPIO + 1;
  localparam int CODE_ONE  = NUM_GPIO + 3;

  logic [NSRC-1:0] src;

  always_comb begin
    src = '0;
    src[NUM_GPIO-1:0] = gpio_i;
    src[CODE_FSI]     = fs_int_i;
    src[CODE_FSE]     = fs_ext_i;
    src[CODE_ONE]     = 1'b1;
  end

  assign bit_o = src[sel_i];
endmodule

// File: rtl/bcgm_port_frame.sv
module bcgm_port_frame
  import bcgm_pkg::*;
#(
  parameter int NUM_GPIO   = 7,
  parameter int NUM_SLOTS  = 4,
  parameter int FRAME_BITS = 30
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bit_en_i,
  input  logic [NUM_SLOTS*SEL_W-1:0] sel_i,
  input  logic [NUM_GPIO-1:0]        gpio_i,
  input  logic                       fs_int_i,
  input  logic                       fs_ext_i,
  output logic [NUM_SLOTS-1:0]       slot_o,
  output logic                       strobe_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]     bit_cnt_q;
  logic [NUM_SLOTS-1:0] pick, slot_q;
  logic                 capture, strobe_q;

  assign capture = bit_en_i && (bit_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         bit_cnt_q <= '0;
    else if (bit_en_i)   bit_cnt_q <= (bit_cnt_q == LAST) ? '0 : bit_cnt_q + 1'b1;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    bcgm_slot_mux #(.NUM_GPIO(NUM_GPIO)) u_mux (
      .sel_i    (sel_i[s*SEL_W +: SEL_W]),
      .gpio_i   (gpio_i),
      .fs_int_i (fs_int_i),
      .fs_ext_i (fs_ext_i),
      .bit_o    (pick[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= capture;
      if (capture) slot_q <= pick;
    end
  end

  assign slot_o   = slot_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/bc_gpio_slot_mapper.sv
module bc_gpio_slot_mapper
  import bcgm_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_GPIO   = 7,
  parameter int FRAME_BITS = 30,
  localparam int NUM_SLOTS = 4,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_GPIO-1:0]           gpio_i,
  input  logic                          fsync_int_i,
  input  logic                          fsync_ext_i,
  input  logic [NUM_PORTS-1:0]          bit_en_i,
  input  logic                          reg_we_i,
  input  logic [PORT_W-1:0]             reg_port_i,
  input  logic                          reg_idx_i,
  input  logic [REG_W-1:0]              reg_wdata_i,
  output logic [REG_W-1:0]              reg_rdata_o,
  output logic [NUM_PORTS*NUM_SLOTS-1:0] slot_o,
  output logic [NUM_PORTS-1:0]          frame_strobe_o
);
  localparam int NUM_REGS = NUM_SLOTS / SLOTS_PER_REG;

  logic [REG_W-1:0]    cfg_q [NUM_PORTS][NUM_REGS];
  logic [NUM_GPIO-1:0] gpio_s;

  bcgm_sync #(.W(NUM_GPIO)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gpio_i),
    .q_o    (gpio_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_SLOTS*SEL_W-1:0] sel;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          cfg_q[p][r] <= CFG_RST;
        else if (reg_we_i && (int'(reg_port_i) == p) && (int'(reg_idx_i) == r))
          cfg_q[p][r] <= reg_wdata_i;
      end
      assign sel[r*REG_W +: REG_W] = cfg_q[p][r];
    end

    bcgm_port_frame #(
      .NUM_GPIO   (NUM_GPIO),
      .NUM_SLOTS  (NUM_SLOTS),
      .FRAME_BITS (FRAME_BITS)
    ) u_frame (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bit_en_i (bit_en_i[p]),
      .sel_i    (sel),
      .gpio_i   (gpio_s),
      .fs_int_i (fsync_int_i),
      .fs_ext_i (fsync_ext_i),
      .slot_o   (slot_o[p*NUM_SLOTS +: NUM_SLOTS]),
      .strobe_o (frame_strobe_o[p])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (int'(reg_port_i) == p) reg_rdata_o = cfg_q[p][reg_idx_i];
  end
endmodule

// File: rtl/bcgm_checker.sv
module bcgm_checker #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_PORTS-1:0]       bit_en_i,
  input logic                       reg_we_i,
  input logic [PORT_W-1:0]          reg_port_i,
  input logic                       reg_idx_i,
  input logic [7:0]                 reg_wdata_i,
  input logic [7:0]                 reg_rdata_o,
  input logic [NUM_PORTS*4-1:0]     slot_o,
  input logic [NUM_PORTS-1:0]       frame_strobe_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_slot_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_strobe_o[p] |-> $stable(slot_o[p*4 +: 4]));
    assert_strobe_needs_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_strobe_o[p] |-> $past(bit_en_i[p]));
    assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_strobe_o[p] |=> !frame_strobe_o[p]);
  end

  assert_write_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> ((reg_port_i == $past(reg_port_i) && reg_idx_i == $past(reg_idx_i))
                  ? (reg_rdata_o == $past(reg_wdata_i)) : 1'b1));
endmodule

bind bc_gpio_slot_mapper bcgm_checker #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bit_en_i       (bit_en_i),
  .reg_we_i       (reg_we_i),
  .reg_port_i     (reg_port_i),
  .reg_idx_i      (reg_idx_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .slot_o         (slot_o),
  .frame_strobe_o (frame_strobe_o)
);

// File: tb/bc_gpio_slot_mapper_tb.sv
module bc_gpio_slot_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int FB = 30;

  logic clk = 0, rst_ni = 0;
  logic [6:0] gpio = '0;
  logic fs_int = 0, fs_ext = 0;
  logic [NP-1:0] bit_en = '0;
  logic we = 0, idx = 0;
  logic [1:0] port = '0;
  logic [7:0] wdata = '0, rdata;
  logic [NP*4-1:0] slot;
  logic [NP-1:0] stb;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bc_gpio_slot_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .gpio_i(gpio), .fsync_int_i(fs_int),
    .fsync_ext_i(fs_ext), .bit_en_i(bit_en), .reg_we_i(we), .reg_port_i(port),
    .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .slot_o(slot), .frame_strobe_o(stb)
  );

  // reference model
  logic [6:0] hist[$];
  int         m_cnt [NP];
  logic [3:0] m_slot[NP];
  logic       m_stb [NP];
  logic [7:0] m_cfg [NP][2];

  function automatic logic pick(int code, logic [6:0] g, logic fi, logic fe);
    if (code < 7) return g[code];
    if (code == 7) return fi;
    if (code == 8) return fe;
    if (code == 10) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{7'd0, 7'd0};
      for (int p = 0; p < NP; p++) begin
        m_cnt[p] = 0; m_slot[p] = '0; m_stb[p] = 0;
        m_cfg[p][0] = 8'h99; m_cfg[p][1] = 8'h99;
      end
    end else begin
      logic [6:0] gs;
      gs = hist[0];
      for (int p = 0; p < NP; p++) begin
        m_stb[p] = 0;
        if (bit_en[p]) begin
          if (m_cnt[p] == 0) begin
            for (int s = 0; s < 4; s++) begin
              int code;
              code = (s < 2) ? int'(m_cfg[p][0] >> (4*s)) & 15 : int'(m_cfg[p][1] >> (4*(s-2))) & 15;
              m_slot[p][s] = pick(code, gs, fs_int, fs_ext);
            end
            m_stb[p] = 1;
          end
          m_cnt[p] = (m_cnt[p] + 1) % FB;
        end
      end
      if (we) m_cfg[port][idx] = wdata;
      hist.push_back(gpio);
      void'(hist.pop_front());
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison (R8 outputs, R2 readback)
  always @(negedge clk) if (rst_ni) begin
    for (int p = 0; p < NP; p++) begin
      check("R8 model slot", {28'd0, slot[p*4 +: 4]}, {28'd0, m_slot[p]});
      check("R8 model strobe", {31'd0, stb[p]}, {31'd0, m_stb[p]});
    end
    check("R2 model rdata", {24'd0, rdata}, {24'd0, m_cfg[port][idx]});
  end

  task automatic wr(int p, int i, logic [7:0] v);
    @(negedge clk); we = 1; port = 2'(p); idx = 1'(i); wdata = v;
    @(negedge clk); we = 0;
  endtask

  task automatic pulse(logic [NP-1:0] m, int n);
    repeat (n) begin
      @(negedge clk); bit_en = m;
      @(negedge clk); bit_en = '0;
    end
  endtask

  task automatic rd(int p, int i, logic [7:0] exp, string req);
    @(negedge clk); port = 2'(p); idx = 1'(i);
    #1 check(req, {24'd0, rdata}, {24'd0, exp});
  endtask

  function automatic logic [3:0] sl(int p);
    return slot[p*4 +: 4];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 reset slots", {16'd0, slot}, 32'd0);
    check("R1 reset strobe", {28'd0, stb}, 32'd0);
    rd(2, 1, 8'h99, "R1 reset cfg");

    // R2, R3, R4 on port 0: slot0=g0, slot1=g3, slot2=g3, slot3=g6
    wr(0, 0, 8'h30);
    wr(0, 1, 8'h63);
    rd(0, 0, 8'h30, "R2 readback idx0");
    rd(0, 1, 8'h63, "R2 readback idx1");
    rd(1, 0, 8'h99, "R2 other port untouched");
    gpio = 7'b1001001; repeat (3) @(negedge clk);
    pulse(4'b0001, FB);
    check("R3 distinct pins", {28'd0, sl(0)}, 32'hF);
    gpio = 7'b0001000; repeat (3) @(negedge clk);
    pulse(4'b0001, FB);
    check("R4 shared source", {28'd0, sl(0)}, 32'h6);

    // R5, R6 on port 1: slot0=fs_int, slot1=fs_ext, slot2=0, slot3=1
    wr(1, 0, 8'h87);
    wr(1, 1, 8'hA9);
    fs_int = 1; fs_ext = 0;
    pulse(4'b0010, FB);
    check("R5 int sync", {28'd0, sl(1)}, 32'h9);
    check("R9 port0 held", {28'd0, sl(0)}, 32'h6);
    fs_int = 0; fs_ext = 1;
    pulse(4'b0010, FB);
    check("R5 ext sync", {28'd0, sl(1)}, 32'hA);

    // R6 on port 2: codes 15, 11, 9, 10
    wr(2, 0, 8'hBF);
    wr(2, 1, 8'hA9);
    gpio = 7'h7F; fs_int = 1; repeat (3) @(negedge clk);
    pulse(4'b0100, FB);
    check("R6 unused codes and constants", {28'd0, sl(2)}, 32'h8);

    // R3 synchronizer latency on port 3: all slots g0
    wr(3, 0, 8'h00);
    wr(3, 1, 8'h00);
    gpio = 7'h00; repeat (3) @(negedge clk);
    @(negedge clk); gpio = 7'h01; bit_en = 4'b1000;
    @(negedge clk); bit_en = '0;
    check("R3 pin change too late", {28'd0, sl(3)}, 32'h0);
    check("R8 strobe after capture", {31'd0, stb[3]}, 32'h1);
    @(negedge clk);
    check("R8 strobe one cycle", {31'd0, stb[3]}, 32'h0);
    pulse(4'b1000, FB - 1);
    pulse(4'b1000, 1);
    check("R3 pin seen next frame", {28'd0, sl(3)}, 32'hF);
    check("R9 port2 held", {28'd0, sl(2)}, 32'h8);

    // R7 mid-frame change on port 0
    gpio = 7'h00; repeat (3) @(negedge clk);
    pulse(4'b0001, 1);
    check("R7 frame start capture", {28'd0, sl(0)}, 32'h0);
    gpio = 7'b1001001; repeat (3) @(negedge clk);
    pulse(4'b0001, FB - 2);
    check("R7 mid frame ignored", {28'd0, sl(0)}, 32'h0);
    pulse(4'b0001, 1);
    check("R7 last bit ignored", {28'd0, sl(0)}, 32'h0);
    pulse(4'b0001, 1);
    check("R7 next frame capture", {28'd0, sl(0)}, 32'hF);
    rd(3, 1, 8'h00, "R2 port3 idx1");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule